// File: doc/BRIEF.md
# E1 Frame Alignment Detector

This block takes an already bit-synchronised E1 line, presented as one data bit per cycle with a qualifying strobe, and finds where each 256-bit frame begins. It hunts for the 7-bit alignment word carried in timeslot 0. That word is present only on every second frame. The block confirms a candidate over two further frame periods and then declares lock. From then on it labels the stream with a timeslot index, a bit index and a frame-start pulse, so that later stages can pick channels out of the line without doing any framing of their own.

While locked, the block keeps checking the word in every frame that should carry it. After a run of consecutive misses it gives up, raises a loss-of-frame flag and starts hunting again. Clock recovery, line decoding, multiframe CRC and the contents of the frames that carry no alignment word are handled elsewhere.

Top module: `e1_frame_aligner`

## Requirements
- R1: A synchronous active-low reset puts the block in hunt with `locked`=0, `lof`=0, `frame_start`=0, `ts_idx`=0, `bit_idx`=0. It also fills the 7-bit history of received bits with ones, so no match can form until 7 real bits have arrived.
- R2: A bit is accepted only in a cycle with `bit_vld`=1. In any other cycle, `bit_in` is ignored and the position outputs hold their values.
- R3: `ts_idx`/`bit_idx` give the position that the next accepted bit will occupy. `bit_idx` 0 is the first transmitted bit of a timeslot (bit 1) and 7 is the last (bit 8). The position advances by one for each accepted bit, and `ts_idx` wraps from 31 to 0.
- R4: In hunt, a match occurs when the last 7 accepted bits, the current one included and oldest first, equal 0011011. The current bit is then taken to be bit 8 of timeslot 0, so the outputs show `ts_idx`=1, `bit_idx`=0 after that bit.
- R5: While confirming, the block also checks the bits 2..8 position of timeslot 0 in the intervening frame, 256 bits after the candidate. If the pattern appears there, the candidate is dropped and the block returns to hunt.
- R6: If the pattern appears again 512 accepted bits after the candidate and the R5 check has passed, `locked` rises. If it does not appear, the block returns to hunt.
- R7: Bit 1 of timeslot 0 (`bit_idx` 0) takes no part in any comparison. Any value there leaves the lock unaffected.
- R8: While locked, each check on an expected alignment frame that misses the pattern counts as a miss, and a hit clears the count. On the third consecutive miss, `locked` falls and `lof` rises. `lof` stays high until lock is next declared. One or two misses leave the lock in place.
- R9: `frame_start` is 1 exactly while locked with `ts_idx`=0 and `bit_idx`=0, that is, for the one bit period before the first bit of every frame is accepted.
- R10: Hunt slides one bit at a time. After any failed confirmation, the very next accepted bit is examined again as a possible candidate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_vld | input | 1 | Qualifies `bit_in` for this cycle |
| bit_in | input | 1 | Mid-bit sampled line data |
| frame_start | output | 1 | High while the next accepted bit opens a frame (locked only) |
| ts_idx | output | 5 | Timeslot of the next accepted bit |
| bit_idx | output | 3 | Bit within timeslot of the next accepted bit, 0 = first |
| locked | output | 1 | Frame alignment established |
| lof | output | 1 | Alignment was lost and has not yet been regained |

## Verification
An idle-ones line with a random starting phase and gaps in the strobe shows that lock is reached at the true boundary and that the indices line up with the generator's own frame position. A seven-bit burst straight after reset isolates the candidate load, and a strobe-low window with a toggling data input isolates the hold behaviour. A line that carries the word in every frame separates the intervening-frame rule from a plain repeat check. Corrupting two and then three consecutive alignment words separates tolerated misses from loss. A line with dense random traffic causes false candidates and checks that the hunt recovers from them.

// File: rtl/e1fa_pkg.sv
// Package: shared types and constants of the E1 frame alignment detector.
// Assumes: one alignment word of TS_BITS-1 bits, sent earliest bit first.
package e1fa_pkg;

    // Controller states: search, verify candidate, aligned
    typedef enum logic [1:0] {
        ST_HUNT    = 2'd0,
        ST_CONFIRM = 2'd1,
        ST_LOCK    = 2'd2
    } fa_state_t;

    // Default alignment word, oldest bit in the MSB
    localparam logic [6:0] FAW_DEFAULT = 7'b0011011;

endpackage

// File: rtl/e1fa_history.sv
// Module: bit history and pattern comparator.
// Keeps the previous LEN-1 accepted bits and compares them, together with
// the bit being accepted now, against PAT (oldest bit in MSB).
// Assumes: history filled with ones at reset, so PAT must start with 0 for
// a partial history never to match.
module e1fa_history #(
    parameter int LEN = 7,
    parameter logic [LEN-1:0] PAT = 7'b0011011
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_vld,
    input  logic bit_in,
    output logic match
);

    logic [LEN-2:0] hist_q;
    logic [LEN-1:0] window;

    // Window = stored history followed by the current bit
    always_comb begin
        window = {hist_q, bit_in};
        match  = (window == PAT);
    end

    // Shift accepted bits into the history
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= '1;
        end else if (bit_vld) begin
            hist_q <= window[LEN-2:0];
        end
    end

endmodule

// File: rtl/e1fa_pos_cnt.sv
// Module: double-frame bit position counter.
// Holds the position (0 .. 2^POS_W-1) of the next accepted bit. Advances on
// each accepted bit and wraps naturally; 'load' forces LOAD_VAL instead.
// Assumes: two frames span exactly 2^POS_W bits.
module e1fa_pos_cnt #(
    parameter int POS_W    = 9,
    parameter int LOAD_VAL = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_vld,
    input  logic             load,
    output logic [POS_W-1:0] pos
);

    localparam logic [POS_W-1:0] LOAD_P = POS_W'(LOAD_VAL);

    // Advance or reload the position on each accepted bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos <= '0;
        end else if (bit_vld) begin
            pos <= load ? LOAD_P : pos + 1'b1;
        end
    end

    // R2: no accepted bit, no movement
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_vld |=> $stable(pos));

    // R3: an accepted bit without reload moves the position by one
    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_vld && !load) |=> pos == $past(pos) + 1'b1);

endmodule

// File: rtl/e1fa_ctrl.sv
// Module: hunt / confirm / lock controller.
// Uses the comparator result and the position counter to decide when a
// candidate boundary is taken, confirmed, kept or lost.
// Assumes: 'match' and 'pos' describe the bit accepted in this cycle; the
// alignment word ends at position CHECK_POS of the first frame of a pair.
module e1fa_ctrl
    import e1fa_pkg::*;
#(
    parameter int POS_W      = 9,
    parameter int FRAME_BITS = 256,
    parameter int CHECK_POS  = 7,
    parameter int MISS_LIMIT = 3,
    localparam int MISS_W    = $clog2(MISS_LIMIT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_vld,
    input  logic             match,
    input  logic [POS_W-1:0] pos,
    output logic             load,
    output logic             locked,
    output logic             lof
);

    localparam logic [POS_W-1:0]  CHK      = POS_W'(CHECK_POS);
    localparam logic [POS_W-1:0]  MID      = POS_W'(CHECK_POS + FRAME_BITS);
    localparam logic [MISS_W-1:0] LAST_MIS = MISS_W'(MISS_LIMIT - 1);

    fa_state_t         state_q, state_d;
    logic [MISS_W-1:0] miss_q, miss_d;
    logic              lof_q, lof_d;

    // Next-state decision for each accepted bit
    always_comb begin
        state_d = state_q;
        miss_d  = miss_q;
        lof_d   = lof_q;
        load    = 1'b0;
        if (bit_vld) begin
            case (state_q)
                ST_HUNT: begin
                    if (match) begin
                        load    = 1'b1;
                        state_d = ST_CONFIRM;
                    end
                end
                ST_CONFIRM: begin
                    if (pos == MID && match) begin
                        state_d = ST_HUNT;
                    end else if (pos == CHK) begin
                        if (match) begin
                            state_d = ST_LOCK;
                            miss_d  = '0;
                            lof_d   = 1'b0;
                        end else begin
                            state_d = ST_HUNT;
                        end
                    end
                end
                ST_LOCK: begin
                    if (pos == CHK) begin
                        if (match) begin
                            miss_d = '0;
                        end else if (miss_q == LAST_MIS) begin
                            state_d = ST_HUNT;
                            miss_d  = '0;
                            lof_d   = 1'b1;
                        end else begin
                            miss_d = miss_q + 1'b1;
                        end
                    end
                end
                default: state_d = ST_HUNT;
            endcase
        end
    end

    // Register controller state, miss count and loss flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
            miss_q  <= '0;
            lof_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            miss_q  <= miss_d;
            lof_q   <= lof_d;
        end
    end

    assign locked = (state_q == ST_LOCK);
    assign lof    = lof_q;

    // R6: lock is only ever entered from confirmation
    p_lock_path_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(state_q) == ST_CONFIRM);

    // R5: pattern in the intervening frame drops the candidate
    p_mid_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CONFIRM && bit_vld && pos == MID && match)
        |=> state_q == ST_HUNT);

    // R8: leaving lock always raises the loss flag
    p_loss_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(locked) |-> lof);

    // R8: the miss count never reaches the limit
    p_miss_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
        miss_q < MISS_W'(MISS_LIMIT));

endmodule

// File: rtl/e1_frame_aligner.sv
// Module: E1 frame alignment detector (top).
// Finds the frame boundary of a sampled E1 bit stream from the alignment
// word in timeslot 0 of alternate frames, then labels every bit with its
// timeslot and bit index and pulses frame_start once per frame.
// Assumes: bits already recovered at mid-bit; TS_NUM*TS_BITS*2 is a power
// of two; the word occupies bits 2..TS_BITS of timeslot 0.
module e1_frame_aligner
    import e1fa_pkg::*;
#(
    parameter int TS_NUM     = 32,
    parameter int TS_BITS    = 8,
    parameter int MISS_LIMIT = 3,
    parameter logic [TS_BITS-2:0] FAW = FAW_DEFAULT,
    localparam int TS_W      = $clog2(TS_NUM),
    localparam int BIT_W     = $clog2(TS_BITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_vld,
    input  logic             bit_in,
    output logic             frame_start,
    output logic [TS_W-1:0]  ts_idx,
    output logic [BIT_W-1:0] bit_idx,
    output logic             locked,
    output logic             lof
);

    localparam int FRAME_BITS = TS_NUM * TS_BITS;
    localparam int POS_W      = $clog2(2 * FRAME_BITS);
    localparam int CHECK_POS  = TS_BITS - 1;

    logic             match;
    logic             load;
    logic [POS_W-1:0] pos;

    e1fa_history #(
        .LEN (TS_BITS - 1),
        .PAT (FAW)
    ) u_hist (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_vld (bit_vld),
        .bit_in  (bit_in),
        .match   (match)
    );

    e1fa_pos_cnt #(
        .POS_W    (POS_W),
        .LOAD_VAL (CHECK_POS + 1)
    ) u_pos (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_vld (bit_vld),
        .load    (load),
        .pos     (pos)
    );

    e1fa_ctrl #(
        .POS_W      (POS_W),
        .FRAME_BITS (FRAME_BITS),
        .CHECK_POS  (CHECK_POS),
        .MISS_LIMIT (MISS_LIMIT)
    ) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .bit_vld (bit_vld),
        .match   (match),
        .pos     (pos),
        .load    (load),
        .locked  (locked),
        .lof     (lof)
    );

    // Split the position into timeslot and bit, flag the frame opening
    always_comb begin
        bit_idx     = pos[BIT_W-1:0];
        ts_idx      = pos[POS_W-2:BIT_W];
        frame_start = locked && (pos[POS_W-2:0] == '0);
    end

    // R1: reset leaves the outputs idle
    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (!locked && !lof && !frame_start && ts_idx == '0 && bit_idx == '0));

    // R9: frame_start only while aligned
    p_fs_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> locked);

    // R4: a hunt match places the next bit in timeslot 1, bit 0
    p_cand_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!locked && load) |=> (ts_idx == TS_W'(1) && bit_idx == '0));

endmodule

// File: tb/e1_frame_aligner_tb_top.sv
// Bench: behavioural reference model compared every cycle, plus directed
// checks against the stimulus generator's own frame position.
module e1_frame_aligner_tb_top;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst_n, bit_vld, bit_in;
    logic       frame_start, locked, lof;
    logic [4:0] ts_idx;
    logic [2:0] bit_idx;

    e1_frame_aligner dut_i (
        .clk (clk), .rst_n (rst_n), .bit_vld (bit_vld), .bit_in (bit_in),
        .frame_start (frame_start), .ts_idx (ts_idx), .bit_idx (bit_idx),
        .locked (locked), .lof (lof)
    );

    localparam bit [6:0] PAT = 7'b0011011;

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    int m_pos, m_state, m_miss;
    bit m_lof;
    bit m_hist[$];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pos = 0; m_state = 0; m_miss = 0; m_lof = 0;
            m_hist.delete();
            repeat (7) m_hist.push_back(1'b1);
        end else if (bit_vld) begin
            int old;
            bit hit;
            m_hist.push_back(bit_in);
            void'(m_hist.pop_front());
            hit = 1'b1;
            for (int i = 0; i < 7; i++) if (m_hist[i] != PAT[6-i]) hit = 1'b0;
            old = m_pos;
            m_pos = (m_pos + 1) % 512;
            case (m_state)
                0: if (hit) begin m_pos = 8; m_state = 1; end
                1: begin
                    if (old == 263 && hit) m_state = 0;
                    else if (old == 7) begin
                        if (hit) begin m_state = 2; m_miss = 0; m_lof = 0; end
                        else m_state = 0;
                    end
                end
                default: begin
                    if (old == 7) begin
                        if (hit) m_miss = 0;
                        else if (m_miss == 2) begin m_state = 0; m_miss = 0; m_lof = 1; end
                        else m_miss++;
                    end
                end
            endcase
        end
    end

    // Compare model and design away from the active edge
    always @(negedge clk) begin
        bit m_lk;
        m_lk = (m_state == 2);
        chk(locked == m_lk, "R6", "locked vs model", locked, m_lk);
        chk(lof == m_lof, "R8", "lof vs model", lof, m_lof);
        chk(frame_start == (m_lk && (m_pos % 256) == 0), "R9", "frame_start vs model",
            frame_start, (m_lk && (m_pos % 256) == 0));
        chk(ts_idx == (m_pos % 256) / 8, "R3", "ts_idx vs model", ts_idx, (m_pos % 256) / 8);
        chk(bit_idx == m_pos % 8, "R3", "bit_idx vs model", bit_idx, m_pos % 8);
    end

    // ---------------- stimulus generator ----------------
    int gpos, gmode, corrupt_left;
    bit saw_lof, saw_lock;
    int fs_seen;

    // gmode 0: idle traffic, word on even frames; 1: word on every frame;
    // 2: dense random traffic
    function bit gen_bit(int p);
        int ip, ts, b;
        bit odd, v;
        ip = p % 256; ts = ip / 8; b = ip % 8; odd = ((p / 256) % 2) == 1;
        if (ts == 0) begin
            if (b == 0) return bit'($urandom % 2);   // R7 reserved bit random
            if (!odd || gmode == 1) begin
                v = PAT[7-b];
                if (corrupt_left > 0 && b == 3 && !odd) v = ~v;
                return v;
            end
            if (b == 1) return 1'b1;
            return bit'($urandom % 2);
        end
        if (gmode == 2) return ($urandom % 4) != 0;
        return 1'b1;
    endfunction

    task automatic step(int vld_pct);
        @(negedge clk);
        if (locked && !lof) saw_lock = 1'b1;
        if (lof && !locked) saw_lof = 1'b1;
        if (gmode == 0 && locked) begin
            chk(ts_idx == (gpos % 256) / 8, "R3", "ts_idx vs line", ts_idx, (gpos % 256) / 8);
            chk(bit_idx == gpos % 8, "R3", "bit_idx vs line", bit_idx, gpos % 8);
            if (frame_start) begin
                fs_seen++;
                chk((gpos % 256) == 0, "R9", "frame_start line position", gpos % 256, 0);
            end
        end
        if (($urandom % 100) < vld_pct) begin
            bit_vld = 1'b1;
            bit_in  = gen_bit(gpos);
            if (gpos % 512 == 7 && corrupt_left > 0) corrupt_left--;
            gpos = (gpos + 1) % 512;
        end else begin
            bit_vld = 1'b0;
            bit_in  = bit'($urandom % 2);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; bit_vld = 1'b0; bit_in = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic send_raw(bit b);
        @(negedge clk);
        bit_vld = 1'b1;
        bit_in  = b;
    endtask

    task automatic run_until_lock(int max);
        for (int i = 0; i < max && !locked; i++) step(75);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (180000) @(posedge clk);
        n_fail++;
        $display("FAIL R6 watchdog expired: actual 1 expected 0");
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    // ---------------- test sequence ----------------
    initial begin
        rst_n = 1'b0; bit_vld = 1'b0; bit_in = 1'b0;
        gpos = 100; gmode = 0; corrupt_left = 0;
        saw_lof = 0; saw_lock = 0; fs_seen = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!locked && !lof && !frame_start, "R1", "flags after reset",
            {locked, lof, frame_start}, 0);
        chk(ts_idx == 0 && bit_idx == 0, "R1", "indices after reset", {ts_idx, bit_idx}, 0);

        // R4 candidate from exactly seven bits after reset
        for (int i = 6; i >= 0; i--) send_raw(PAT[i]);
        @(negedge clk);
        bit_vld = 1'b0;
        chk(ts_idx == 1 && bit_idx == 0, "R4", "position after candidate",
            ts_idx * 8 + bit_idx, 8);
        chk(!locked, "R4", "candidate is not lock", locked, 0);

        // R2 strobe low: data toggles, nothing moves
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            bit_vld = 1'b0;
            bit_in  = ~bit_in;
        end
        @(negedge clk);
        chk(ts_idx == 1 && bit_idx == 0, "R2", "position held without strobe",
            ts_idx * 8 + bit_idx, 8);

        // R6 / R3 / R9 / R7 idle line with gaps and random reserved bit
        do_reset();
        gmode = 0; gpos = 100;
        run_until_lock(2000);
        chk(locked, "R6", "lock on idle line", locked, 1);
        repeat (2000) step(75);
        chk(locked && !lof, "R7", "lock kept with random reserved bit", locked, 1);
        chk(fs_seen >= 4, "R9", "frame_start pulses seen", fs_seen, 4);

        // R8 two consecutive corrupted words are tolerated
        while (gpos != 300) step(75);
        corrupt_left = 2; saw_lof = 0;
        repeat (1800) step(75);
        chk(locked && !saw_lof, "R8", "two misses keep lock", locked, 1);

        // R8 three consecutive corrupted words lose lock, then relock clears lof
        while (gpos != 300) step(75);
        corrupt_left = 3; saw_lof = 0;
        repeat (3000) step(75);
        chk(saw_lof, "R8", "loss flagged after three misses", saw_lof, 1);
        run_until_lock(2000);
        chk(locked && !lof, "R8", "lof cleared on relock", lof, 0);

        // R5 word in every frame never locks
        do_reset();
        gmode = 1; gpos = 37; saw_lock = 0;
        repeat (3000) step(75);
        chk(!saw_lock, "R5", "no lock when word is in every frame", saw_lock, 0);

        // R10 hunt keeps sliding after failed confirmations
        gmode = 0;
        run_until_lock(2500);
        chk(locked, "R10", "lock after switch to valid line", locked, 1);

        // R4 / R6 dense random traffic with false candidates
        do_reset();
        gmode = 2; gpos = 211;
        run_until_lock(60000);
        chk(locked, "R4", "lock found among false candidates", locked, 1);

        @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule